// File: doc/BRIEF.md
# Vendor Request Register Decoder

This block sits behind a control endpoint that has already split each setup packet into its fields. It receives a request type, a request code and a payload length in one cycle. For writes, the payload bytes follow one per cycle. The block checks each request against a small fixed table of vendor request codes. Each table entry carries its own direction and its own legal payload length. An accepted request is mapped onto a UART-style register set: a clock divisor, a line-format byte and a modem-line control byte. A "CTS may be ignored" enable is also latched here. The latched values feed a downstream serial engine.

Read requests are answered with a one-byte response, one cycle after the setup cycle. A read returns either the line-format byte or the modem-status byte that the serial engine presents. A request that is not in the table, or whose length does not fit its entry, is refused with a one-cycle stall pulse. A refused request leaves every register as it was. A write payload only takes effect when its last byte arrives, so a downstream engine never sees a half-written divisor.

Top module: `vreq_decoder`

## Requirements
- R1: After reset the divisor reads 12, the line-format byte reads 0x03, the modem control byte reads 0x08, and cts_ignore, stall and rd_valid are all low.
- R2: A request with type 0x40, code 5 and length 4 loads the divisor from the four payload bytes, least significant byte first. The new value appears in the cycle after the last byte.
- R3: A divisor write with length 1 sets the divisor to that single byte, with all upper bytes zero.
- R4: Type 0x40, code 7, length 1 loads the line-format byte. Type 0xC0, code 6, length 1 raises rd_valid for one cycle, in the cycle after the setup cycle, with rd_data equal to the line-format byte.
- R5: Type 0x40, code 10, length 1 loads the modem control byte from payload bits 4..0. Bits 7..5 always read zero. Bit 0 is DTR, bit 1 is RTS, bits 2 and 3 are the two auxiliary outputs, and bit 4 is loopback.
- R6: Type 0xC0, code 2, length 1 answers in the next cycle with the value on modem_status sampled in the setup cycle.
- R7: Type 0x40, code 12, length 1 sets cts_ignore once its byte arrives, and cts_ignore stays set until reset. Type 0x40, code 11, length 1 is accepted and changes no output.
- R8: A setup whose type/code pair is not in the table gives stall high for exactly the one cycle after the setup cycle. No register changes, and later payload bytes are ignored.
- R9: A setup whose code is in the table but whose length does not match is refused the same way as R8. Only a divisor write accepts both length 1 and length 4; every other entry accepts only length 1.
- R10: Registers keep their old values until the final payload byte. A new setup abandons any unfinished payload. Data bytes arriving while no write is pending have no effect.
- R11: stall and rd_valid are never high in the same cycle, and a write request raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| setup_valid | input | 1 | Setup fields valid this cycle |
| req_type | input | 8 | Request type (0x40 write, 0xC0 read) |
| req_code | input | 8 | Vendor request code |
| req_len | input | LEN_W | Payload length in bytes |
| data_valid | input | 1 | Payload byte valid this cycle |
| data_byte | input | 8 | Payload byte |
| modem_status | input | 8 | Modem status byte from the serial engine |
| baud_div | output | 8*DIV_BYTES | Latched clock divisor |
| line_ctrl | output | 8 | Latched line-format byte |
| modem_ctrl | output | 8 | Latched modem control byte |
| cts_ignore | output | 1 | Transmit without CTS permitted |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |
| stall | output | 1 | Request refused pulse |

## Verification
Stall and read responses are due in the cycle after the setup cycle. Register updates are due in the cycle after the edge that takes the final payload byte, and no earlier. The bench drives inputs on the falling edge. A behavioural model in the bench updates on the rising edge, and every output is compared 2 ns after each rising edge, so each result is checked in exactly the cycle it is due. Further directed checks, taken at the falling edge after each request completes, cover mid-payload values, refused requests and the sticky enable.

// File: rtl/vreq_pkg.sv
// Package: shared request encodings and decode targets for the vendor
// request decoder. Assumes 8-bit request type and code fields.
package vreq_pkg;
    localparam logic [7:0] TYPE_WR = 8'h40;
    localparam logic [7:0] TYPE_RD = 8'hC0;

    localparam logic [7:0] CODE_DIV_WR = 8'd5;
    localparam logic [7:0] CODE_LCR_WR = 8'd7;
    localparam logic [7:0] CODE_LCR_RD = 8'd6;
    localparam logic [7:0] CODE_MCR_WR = 8'd10;
    localparam logic [7:0] CODE_MSR_RD = 8'd2;
    localparam logic [7:0] CODE_AUX_WR = 8'd11;
    localparam logic [7:0] CODE_CTS_WR = 8'd12;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DIV,
        TGT_LCR,
        TGT_MCR,
        TGT_AUX,
        TGT_CTS,
        TGT_RD_LCR,
        TGT_RD_MSR
    } tgt_e;
endpackage

// File: rtl/vreq_classify.sv
// Module: vreq_classify
// Purely combinational lookup of a setup packet in the request table.
// Returns the target and whether type, code and length all fit an entry.
// Assumes the fields are only meaningful while the caller's setup strobe is high.
module vreq_classify
    import vreq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int DIV_BYTES = 4
) (
    input  logic [7:0]       req_type,
    input  logic [7:0]       req_code,
    input  logic [LEN_W-1:0] req_len,
    output tgt_e             tgt,
    output logic             accept,
    output logic             is_read
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_DIV = LEN_W'(DIV_BYTES);

    // Table lookup: pick the target, then test the length against it
    always_comb begin
        tgt = TGT_NONE;
        if (req_type == TYPE_WR) begin
            unique case (req_code)
                CODE_DIV_WR: tgt = TGT_DIV;
                CODE_LCR_WR: tgt = TGT_LCR;
                CODE_MCR_WR: tgt = TGT_MCR;
                CODE_AUX_WR: tgt = TGT_AUX;
                CODE_CTS_WR: tgt = TGT_CTS;
                default:     tgt = TGT_NONE;
            endcase
        end else if (req_type == TYPE_RD) begin
            unique case (req_code)
                CODE_LCR_RD: tgt = TGT_RD_LCR;
                CODE_MSR_RD: tgt = TGT_RD_MSR;
                default:     tgt = TGT_NONE;
            endcase
        end
        if (tgt == TGT_NONE)
            accept = 1'b0;
        else if (tgt == TGT_DIV)
            accept = (req_len == LEN_DIV) || (req_len == LEN_ONE);
        else
            accept = (req_len == LEN_ONE);
        is_read = (tgt == TGT_RD_LCR) || (tgt == TGT_RD_MSR);
    end
endmodule

// File: rtl/vreq_payload.sv
// Module: vreq_payload
// Collects the payload bytes of an accepted write. The bytes are placed
// least significant first into a shadow word, which is released as a commit
// strobe in the cycle of the final byte. Bytes that were not sent read as zero.
// Assumes start and drop come from the same setup strobe; drop wins over bytes.
module vreq_payload
    import vreq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int DIV_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   drop,
    input  tgt_e                   start_tgt,
    input  logic [LEN_W-1:0]       start_len,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_in,
    output logic                   commit,
    output tgt_e                   commit_tgt,
    output logic [8*DIV_BYTES-1:0] commit_word
);
    logic             busy;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    tgt_e             tgt_q;
    logic [7:0]       shadow [DIV_BYTES];
    logic             last;

    // Final byte of the pending payload is on the input this cycle
    always_comb begin
        last   = (cnt + LEN_W'(1)) == len_q;
        commit = busy && byte_valid && !drop && last;
    end

    assign commit_tgt = tgt_q;

    // Assemble the outgoing word: earlier bytes from the shadow, current byte live
    for (genvar g = 0; g < DIV_BYTES; g++) begin : g_word
        always_comb begin
            if (cnt == LEN_W'(g))
                commit_word[8*g +: 8] = byte_in;
            else if (cnt > LEN_W'(g))
                commit_word[8*g +: 8] = shadow[g];
            else
                commit_word[8*g +: 8] = 8'h00;
        end
    end

    // Track the pending write and store each byte as it arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            len_q <= '0;
            tgt_q <= TGT_NONE;
            for (int i = 0; i < DIV_BYTES; i++) shadow[i] <= 8'h00;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            len_q <= start_len;
            tgt_q <= start_tgt;
        end else if (drop) begin
            busy <= 1'b0;
        end else if (busy && byte_valid) begin
            for (int i = 0; i < DIV_BYTES; i++)
                if (cnt == LEN_W'(i)) shadow[i] <= byte_in;
            cnt <= cnt + LEN_W'(1);
            if (last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/vreq_regs.sv
// Module: vreq_regs
// Holds the divisor, line-format, modem-control and CTS-ignore state.
// Updates only on a commit strobe. Bits 7..5 of the modem control byte
// are never stored. Assumes at most one commit per cycle.
module vreq_regs
    import vreq_pkg::*;
#(
    parameter int         DIV_BYTES = 4,
    parameter int         RESET_DIV = 12,
    parameter logic [7:0] RESET_LCR = 8'h03,
    parameter logic [7:0] RESET_MCR = 8'h08
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  tgt_e                   tgt,
    input  logic [8*DIV_BYTES-1:0] word,
    output logic [8*DIV_BYTES-1:0] div_q,
    output logic [7:0]             lcr_q,
    output logic [7:0]             mcr_q,
    output logic                   cts_q
);
    localparam int DIV_W = 8 * DIV_BYTES;

    // Apply a committed payload to its target register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(RESET_DIV);
            lcr_q <= RESET_LCR;
            mcr_q <= {3'b000, RESET_MCR[4:0]};
            cts_q <= 1'b0;
        end else if (commit) begin
            case (tgt)
                TGT_DIV: div_q <= word;
                TGT_LCR: lcr_q <= word[7:0];
                TGT_MCR: mcr_q <= {3'b000, word[4:0]};
                TGT_CTS: cts_q <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vreq_decoder.sv
// Module: vreq_decoder (top)
// Decodes table-driven vendor control requests into a UART-style register
// set. It answers reads one cycle after setup and refuses bad requests with
// a one-cycle stall. Assumes setup_valid and data_valid are never high together
// when a byte matters; a setup takes precedence over a data byte.
module vreq_decoder
    import vreq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int DIV_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   setup_valid,
    input  logic [7:0]             req_type,
    input  logic [7:0]             req_code,
    input  logic [LEN_W-1:0]       req_len,
    input  logic                   data_valid,
    input  logic [7:0]             data_byte,
    input  logic [7:0]             modem_status,
    output logic [8*DIV_BYTES-1:0] baud_div,
    output logic [7:0]             line_ctrl,
    output logic [7:0]             modem_ctrl,
    output logic                   cts_ignore,
    output logic                   rd_valid,
    output logic [7:0]             rd_data,
    output logic                   stall
);
    localparam int DIV_W = 8 * DIV_BYTES;

    tgt_e             dec_tgt;
    logic             dec_ok;
    logic             dec_rd;
    logic             wr_start;
    logic             cm_valid;
    tgt_e             cm_tgt;
    logic [DIV_W-1:0] cm_word;

    vreq_classify #(.LEN_W(LEN_W), .DIV_BYTES(DIV_BYTES)) u_classify (
        .req_type (req_type),
        .req_code (req_code),
        .req_len  (req_len),
        .tgt      (dec_tgt),
        .accept   (dec_ok),
        .is_read  (dec_rd)
    );

    assign wr_start = setup_valid && dec_ok && !dec_rd;

    vreq_payload #(.LEN_W(LEN_W), .DIV_BYTES(DIV_BYTES)) u_payload (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (wr_start),
        .drop        (setup_valid),
        .start_tgt   (dec_tgt),
        .start_len   (req_len),
        .byte_valid  (data_valid),
        .byte_in     (data_byte),
        .commit      (cm_valid),
        .commit_tgt  (cm_tgt),
        .commit_word (cm_word)
    );

    vreq_regs #(.DIV_BYTES(DIV_BYTES)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (cm_valid),
        .tgt    (cm_tgt),
        .word   (cm_word),
        .div_q  (baud_div),
        .lcr_q  (line_ctrl),
        .mcr_q  (modem_ctrl),
        .cts_q  (cts_ignore)
    );

    // Register the stall pulse and the read response for the cycle after setup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall    <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            stall    <= setup_valid && !dec_ok;
            rd_valid <= setup_valid && dec_ok && dec_rd;
            if (setup_valid && dec_ok && dec_rd)
                rd_data <= (dec_tgt == TGT_RD_LCR) ? line_ctrl : modem_status;
        end
    end
endmodule

// File: rtl/vreq_decoder_chk.sv
// Module: vreq_decoder_chk
// Temporal checks on the decoder's ports, attached through bind.
module vreq_decoder_chk #(
    parameter int LEN_W     = 8,
    parameter int DIV_BYTES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   setup_valid,
    input logic [7:0]             req_type,
    input logic [7:0]             req_code,
    input logic [LEN_W-1:0]       req_len,
    input logic [8*DIV_BYTES-1:0] baud_div,
    input logic [7:0]             line_ctrl,
    input logic [7:0]             modem_ctrl,
    input logic                   cts_ignore,
    input logic                   rd_valid,
    input logic [7:0]             rd_data,
    input logic                   stall
);
    assert_no_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && rd_valid));

    assert_stall_after_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> (stall || rd_valid || $stable(line_ctrl)));

    assert_stall_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> ($stable(baud_div) && $stable(line_ctrl)
                          && $stable(modem_ctrl) && $stable(cts_ignore)));

    assert_stall_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!stall || $past(setup_valid)));

    assert_read_needs_rdtype_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && req_type != 8'hC0) |=> !rd_valid);

    assert_lcr_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && req_type == 8'hC0 && req_code == 8'd6 && req_len == LEN_W'(1))
            |=> (rd_valid && rd_data == line_ctrl));

    assert_mcr_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        modem_ctrl[7:5] == 3'b000);

    assert_cts_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cts_ignore));
endmodule

bind vreq_decoder vreq_decoder_chk #(.LEN_W(LEN_W), .DIV_BYTES(DIV_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_valid (setup_valid),
    .req_type    (req_type),
    .req_code    (req_code),
    .req_len     (req_len),
    .baud_div    (baud_div),
    .line_ctrl   (line_ctrl),
    .modem_ctrl  (modem_ctrl),
    .cts_ignore  (cts_ignore),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .stall       (stall)
);

// File: tb/vreq_decoder_test.sv
module vreq_decoder_test;
    localparam int LEN_W = 8;
    localparam int DIV_BYTES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [7:0]  req_type = 8'h00;
    logic [7:0]  req_code = 8'h00;
    logic [7:0]  req_len = 8'h00;
    logic        data_valid = 1'b0;
    logic [7:0]  data_byte = 8'h00;
    logic [7:0]  modem_status = 8'h00;
    logic [31:0] baud_div;
    logic [7:0]  line_ctrl, modem_ctrl, rd_data;
    logic        cts_ignore, rd_valid, stall;

    int vectors = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model state
    int m_div, m_lcr, m_mcr, m_cts, m_stall, m_rdv, m_rdb;
    int m_busy, m_code, m_len;
    int q[$];

    always #4 clk = ~clk;

    vreq_decoder #(.LEN_W(LEN_W), .DIV_BYTES(DIV_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .req_type(req_type),
        .req_code(req_code), .req_len(req_len), .data_valid(data_valid),
        .data_byte(data_byte), .modem_status(modem_status), .baud_div(baud_div),
        .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .cts_ignore(cts_ignore),
        .rd_valid(rd_valid), .rd_data(rd_data), .stall(stall)
    );

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 12; m_lcr = 3; m_mcr = 8; m_cts = 0;
            m_stall = 0; m_rdv = 0; m_rdb = 0; m_busy = 0;
            q.delete();
        end else begin
            m_stall = 0; m_rdv = 0;
            if (setup_valid) begin
                int ok;
                int rd;
                m_busy = 0; q.delete(); ok = 0; rd = 0;
                if (req_type == 8'h40) begin
                    if (req_code == 5 && (req_len == 4 || req_len == 1)) ok = 1;
                    if ((req_code == 7 || req_code == 10 || req_code == 11 || req_code == 12)
                        && req_len == 1) ok = 1;
                end else if (req_type == 8'hC0) begin
                    if ((req_code == 6 || req_code == 2) && req_len == 1) begin
                        ok = 1; rd = 1;
                    end
                end
                if (!ok) m_stall = 1;
                else if (rd) begin
                    m_rdv = 1;
                    m_rdb = (req_code == 6) ? m_lcr : int'(modem_status);
                end else begin
                    m_busy = 1; m_code = req_code; m_len = req_len;
                end
            end else if (data_valid && m_busy) begin
                q.push_back(int'(data_byte));
                if (q.size() == m_len) begin
                    if (m_code == 5) begin
                        m_div = 0;
                        foreach (q[i]) m_div = m_div + (q[i] << (8 * i));
                    end else if (m_code == 7) m_lcr = q[0];
                    else if (m_code == 10) m_mcr = q[0] & 'h1F;
                    else if (m_code == 12) m_cts = 1;
                    m_busy = 0;
                    q.delete();
                end
            end
        end
    end

    // compare every output against the model shortly after each edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            vectors++;
            if (baud_div !== 32'(m_div) || line_ctrl !== 8'(m_lcr) ||
                modem_ctrl !== 8'(m_mcr) || cts_ignore !== 1'(m_cts) ||
                stall !== 1'(m_stall) || rd_valid !== 1'(m_rdv) ||
                (m_rdv != 0 && rd_data !== 8'(m_rdb))) begin
                errors++;
                $display("FAIL %s t=%0t actual div=%h lcr=%h mcr=%h cts=%b stall=%b rdv=%b rd=%h expected div=%h lcr=%h mcr=%h cts=%0d stall=%0d rdv=%0d rd=%h",
                    cur_req, $time, baud_div, line_ctrl, modem_ctrl, cts_ignore, stall,
                    rd_valid, rd_data, m_div, m_lcr, m_mcr, m_cts, m_stall, m_rdv, m_rdb);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [7:0] t, input logic [7:0] c, input logic [7:0] l);
        @(negedge clk);
        setup_valid = 1'b1; req_type = t; req_code = c; req_len = l;
        @(negedge clk);
        setup_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        data_valid = 1'b1; data_byte = b;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    initial begin
        #160000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 div", baud_div, 32'd12);
        check("R1 lcr", {24'h0, line_ctrl}, 32'h03);
        check("R1 mcr", {24'h0, modem_ctrl}, 32'h08);
        check("R1 flags", {29'h0, cts_ignore, stall, rd_valid}, 32'h0);

        cur_req = "R2";
        setup(8'h40, 8'd5, 8'd4);
        send(8'h45); send(8'h23);
        check("R10 mid payload", baud_div, 32'd12);
        send(8'h01); send(8'h00);
        check("R2 div", baud_div, 32'h0001_2345);

        cur_req = "R10";
        setup(8'h40, 8'd5, 8'd4);
        send(8'hAA); send(8'hBB);
        setup(8'h40, 8'd7, 8'd1);
        send(8'h1B);
        check("R10 abandoned div", baud_div, 32'h0001_2345);
        check("R10 lcr", {24'h0, line_ctrl}, 32'h1B);
        send(8'hFF);
        check("R10 stray byte", {24'h0, line_ctrl}, 32'h1B);

        cur_req = "R3";
        setup(8'h40, 8'd5, 8'd1);
        send(8'h06);
        check("R3 short div", baud_div, 32'd6);

        cur_req = "R4";
        setup(8'h40, 8'd7, 8'd1);
        send(8'h3A);
        setup(8'hC0, 8'd6, 8'd1);
        check("R4 readback", {23'h0, rd_valid, rd_data}, {23'h0, 1'b1, 8'h3A});

        cur_req = "R5";
        setup(8'h40, 8'd10, 8'd1);
        send(8'hFF);
        check("R5 mcr masked", {24'h0, modem_ctrl}, 32'h1F);
        setup(8'h40, 8'd10, 8'd1);
        send(8'h02);
        check("R5 rts only", {24'h0, modem_ctrl}, 32'h02);

        cur_req = "R6";
        modem_status = 8'hA5;
        setup(8'hC0, 8'd2, 8'd1);
        modem_status = 8'h00;
        check("R6 status", {23'h0, rd_valid, rd_data}, {23'h0, 1'b1, 8'hA5});

        cur_req = "R7";
        setup(8'h40, 8'd11, 8'd1);
        send(8'h00);
        check("R7 aux no effect", {31'h0, cts_ignore}, 32'h0);
        check("R7 aux regs", {line_ctrl, modem_ctrl}, {16'h0, 8'h3A, 8'h02});
        setup(8'h40, 8'd12, 8'd1);
        send(8'h00);
        check("R7 cts set", {31'h0, cts_ignore}, 32'h1);
        setup(8'h40, 8'd5, 8'd4);
        send(8'h01); send(8'h00); send(8'h00); send(8'h00);
        check("R7 cts sticky", {31'h0, cts_ignore}, 32'h1);

        cur_req = "R8";
        setup(8'h40, 8'd3, 8'd1);
        check("R8 bad code stall", {31'h0, stall}, 32'h1);
        @(negedge clk);
        check("R8 stall width", {31'h0, stall}, 32'h0);
        send(8'h77);
        check("R8 regs kept", {line_ctrl, modem_ctrl}, {16'h0, 8'h3A, 8'h02});
        setup(8'h21, 8'd7, 8'd1);
        check("R8 bad type stall", {31'h0, stall}, 32'h1);
        setup(8'hC0, 8'd7, 8'd1);
        check("R8 wrong dir stall", {30'h0, stall, rd_valid}, 32'h2);

        cur_req = "R9";
        setup(8'h40, 8'd7, 8'd2);
        check("R9 lcr len2", {31'h0, stall}, 32'h1);
        setup(8'h40, 8'd5, 8'd2);
        check("R9 div len2", {31'h0, stall}, 32'h1);
        send(8'h55); send(8'h66);
        check("R9 div kept", baud_div, 32'd1);
        setup(8'hC0, 8'd6, 8'd0);
        check("R9 read len0", {30'h0, stall, rd_valid}, 32'h2);

        cur_req = "R11";
        setup(8'h40, 8'd7, 8'd1);
        check("R11 write quiet", {30'h0, stall, rd_valid}, 32'h0);
        send(8'h03);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule